// File: doc/BRIEF.md
# Finished-Load Ordering Violation Detector

This block tracks loads that have already received their data while older stores in program order may still be pending. Each such load is recorded with its address, its program-order tag and the data it returned. When a store completes, its address is compared against every recorded load that is younger than the store. Any hit means that load read stale memory. The block then raises a one-cycle rollback request that names the oldest offending load. It also drops that load and every recorded load younger than it, because the surrounding pipeline will re-execute all of them.

A load leaves the buffer when it retires as the oldest instruction. The commit port names it by tag. The same port also acts as a lookup: it reports whether a tag is present and returns the data buffered for it. A load that arrives while all slots are occupied is held off with a ready signal. A load that arrives in the same cycle as a completing store is checked against that store as if it were already buffered.

Top module: `load_order_guard`

## Requirements
- R1: After reset the buffer is empty: `ld_ready` is 1, `rb_valid` is 0 and `cm_hit` is 0 for every tag.
- R2: A load is taken at a rising edge when `ld_valid` and `ld_ready` are both 1. From the next cycle, presenting its tag on `cm_tag` gives `cm_hit`=1, and `cm_data` returns the data captured with it.
- R3: The buffer holds at most ENTRIES (default 8) loads. `ld_ready` is 0 while all are occupied, and a load offered then is not taken: its tag later gives `cm_hit`=0.
- R4: When `cm_valid` is 1 at a rising edge, the entry whose tag equals `cm_tag` is removed. Its tag then gives `cm_hit`=0, and its slot becomes free, so `ld_ready` returns to 1 after a full buffer.
- R5: Tags are TAG_W bits wide, with the top bit a wrap flag. Tag a is older than tag b when (low bits of a < low bits of b) differs from (wrap bits differ). Only loads strictly younger than the store are candidates. A matching load that is older than the store causes nothing.
- R6: A match is a store with `st_valid`=1 whose `st_addr` exactly equals a candidate's address. The edge after that cycle, `rb_valid` is 1 for one cycle, and `rb_tag` carries the oldest matching candidate's tag.
- R7: At the same edge, every entry whose tag equals `rb_tag` or is younger than it is removed, whether it matched or not. Older entries are kept.
- R8: A load offered in the same cycle as a completing store is a candidate. If it is younger than the store and has the same address, it can be the reported load. A load that is equal to or younger than the reported tag is not inserted. An older load is inserted normally.
- R9: A store with no matching younger load produces no rollback and leaves every entry in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | A finished load is offered |
| ld_ready | output | 1 | A free slot exists |
| ld_tag | input | TAG_W | Program-order tag of the offered load |
| ld_addr | input | ADDR_W | Address the load read |
| ld_data | input | DATA_W | Data the load returned |
| st_valid | input | 1 | A store completes this cycle |
| st_tag | input | TAG_W | Program-order tag of the store |
| st_addr | input | ADDR_W | Address written by the store |
| cm_valid | input | 1 | Remove the entry named by cm_tag |
| cm_tag | input | TAG_W | Tag to look up or remove |
| cm_hit | output | 1 | An entry with cm_tag is present |
| cm_data | output | DATA_W | Data of that entry, 0 if absent |
| rb_valid | output | 1 | One-cycle rollback request |
| rb_tag | output | TAG_W | Tag of the oldest offending load |

## Verification
The bench sweeps the store's position across a window of six buffered loads that share three addresses. This exposes any design that reports the youngest hit instead of the oldest, or that keeps non-matching younger entries after a rollback. The same sweep runs from a base where the tags cross the wrap flag, so a plain magnitude comparison of tags would flag the wrong loads. It also checks a same-address load that is older than the store, which must not trigger anything. Same-cycle store and load pairs are checked in both age orders, to catch a detector that ignores the incoming load or inserts it after reporting it. A full buffer is checked to confirm that an offered load is really refused, and a commit to confirm that it frees a slot.

// File: rtl/load_order_guard.sv
`timescale 1ns/1ps
module load_order_guard #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 64,
  parameter int TAG_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              st_valid,
  input  logic [TAG_W-1:0]  st_tag,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              cm_valid,
  input  logic [TAG_W-1:0]  cm_tag,
  output logic              cm_hit,
  output logic [DATA_W-1:0] cm_data,
  output logic              rb_valid,
  output logic [TAG_W-1:0]  rb_tag
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  function automatic logic older(input logic [TAG_W-1:0] a, input logic [TAG_W-1:0] b);
    return (a[TAG_W-2:0] < b[TAG_W-2:0]) ^ (a[TAG_W-1] != b[TAG_W-1]);
  endfunction

  logic [ENTRIES-1:0] vld;
  logic [TAG_W-1:0]   e_tag  [ENTRIES];
  logic [ADDR_W-1:0]  e_addr [ENTRIES];
  logic [DATA_W-1:0]  e_data [ENTRIES];

  logic               found;
  logic [TAG_W-1:0]   worst;
  logic [ENTRIES-1:0] kill;
  logic               ld_take;
  logic               ld_keep;
  logic               free_ok;
  logic [IDX_W-1:0]   free_idx;

  assign ld_ready = ~&vld;
  assign ld_take  = ld_valid && ld_ready;

  always_comb begin
    found = 1'b0;
    worst = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (vld[i] && st_valid && e_addr[i] == st_addr && older(st_tag, e_tag[i]) &&
          (!found || older(e_tag[i], worst))) begin
        found = 1'b1;
        worst = e_tag[i];
      end
    end
    if (ld_take && st_valid && ld_addr == st_addr && older(st_tag, ld_tag) &&
        (!found || older(ld_tag, worst))) begin
      found = 1'b1;
      worst = ld_tag;
    end
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++)
      kill[i] = found && !older(e_tag[i], worst);
  end

  assign ld_keep = !(found && !older(ld_tag, worst));

  always_comb begin
    free_ok  = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        free_ok  = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    cm_hit  = 1'b0;
    cm_data = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (vld[i] && e_tag[i] == cm_tag) begin
        cm_hit  = 1'b1;
        cm_data = e_data[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld      <= '0;
      rb_valid <= 1'b0;
      rb_tag   <= '0;
    end else begin
      rb_valid <= found;
      if (found) rb_tag <= worst;
      for (int i = 0; i < ENTRIES; i++)
        if (vld[i] && (kill[i] || (cm_valid && e_tag[i] == cm_tag)))
          vld[i] <= 1'b0;
      if (ld_take && ld_keep && free_ok)
        vld[free_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_take && ld_keep && free_ok) begin
      e_tag[free_idx]  <= ld_tag;
      e_addr[free_idx] <= ld_addr;
      e_data[free_idx] <= ld_data;
    end
  end

  p_rb_from_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rb_valid |-> $past(st_valid));

  p_rb_younger_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rb_valid |-> older($past(st_tag), rb_tag));

  p_insert_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready && !st_valid && !cm_valid) |=>
      ($countones(vld) == $past($countones(vld)) + 1));

  p_commit_shrinks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && cm_hit && !ld_valid && !st_valid) |=>
      ($countones(vld) + 1 == $past($countones(vld))));

  p_quiet_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_valid && !ld_valid && !cm_valid) |=> (!rb_valid && $stable(vld)));
endmodule

// File: tb/load_order_guard_test.sv
`timescale 1ns/1ps
module load_order_guard_test;
  localparam int AW = 8, DW = 16, TW = 5, NE = 8;

  logic clk = 0, rst_n = 0;
  logic ld_valid = 0, st_valid = 0, cm_valid = 0;
  logic [TW-1:0] ld_tag = 0, st_tag = 0, cm_tag = 0;
  logic [AW-1:0] ld_addr = 0, st_addr = 0;
  logic [DW-1:0] ld_data = 0;
  logic ld_ready, cm_hit, rb_valid;
  logic [DW-1:0] cm_data;
  logic [TW-1:0] rb_tag;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  load_order_guard #(.ENTRIES(NE), .ADDR_W(AW), .DATA_W(DW), .TAG_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_tag(ld_tag),
    .ld_addr(ld_addr), .ld_data(ld_data), .st_valid(st_valid), .st_tag(st_tag),
    .st_addr(st_addr), .cm_valid(cm_valid), .cm_tag(cm_tag), .cm_hit(cm_hit),
    .cm_data(cm_data), .rb_valid(rb_valid), .rb_tag(rb_tag));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; ld_valid = 0; st_valid = 0; cm_valid = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  task automatic push(input int tag, input int addr, input int data);
    ld_valid = 1; ld_tag = TW'(tag); ld_addr = AW'(addr); ld_data = DW'(data);
    @(negedge clk);
    ld_valid = 0;
  endtask

  task automatic store(input int tag, input int addr);
    st_valid = 1; st_tag = TW'(tag); st_addr = AW'(addr);
    @(negedge clk);
    st_valid = 0;
  endtask

  task automatic look(input int tag, output logic hit, output logic [DW-1:0] data);
    cm_tag = TW'(tag);
    #1;
    hit = cm_hit; data = cm_data;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic h;
    logic [DW-1:0] d;
    do_reset();
    // R1 reset state
    look(3, h, d);
    check("R1 ready", ld_ready, 1);
    check("R1 rb_valid", rb_valid, 0);
    check("R1 hit", h, 0);

    // R2/R3 fill and overflow
    for (int i = 1; i <= NE; i++) begin
      check("R3 ready before fill", ld_ready, 1);
      push(i, 10 + i, 16'hA000 + i);
    end
    check("R3 ready when full", ld_ready, 0);
    push(9, 30, 16'hBEEF);
    look(9, h, d);
    check("R3 refused load", h, 0);
    for (int i = 1; i <= NE; i++) begin
      look(i, h, d);
      check("R2 hit", h, 1);
      check("R2 data", d, 16'hA000 + i);
    end

    // R4 commit
    cm_valid = 1; cm_tag = 1;
    @(negedge clk);
    cm_valid = 0;
    look(1, h, d);
    check("R4 removed", h, 0);
    check("R4 ready", ld_ready, 1);
    look(2, h, d);
    check("R4 other kept", h, 1);

    // R9 no match
    store(0, 99);
    check("R9 rb_valid", rb_valid, 0);
    for (int i = 2; i <= NE; i++) begin
      look(i, h, d);
      check("R9 kept", h, 1);
    end
    // R5 older load with same address ignored
    store(9, 12);
    check("R5 older load no rb", rb_valid, 0);
    look(2, h, d);
    check("R5 older load kept", h, 1);

    // R5/R6/R7 sweep, including tag wrap
    for (int b = 0; b < 2; b++) begin
      for (int s = 0; s <= 6; s++) begin
        for (int a = 0; a < 4; a++) begin
          int base, kmin;
          base = b ? 27 : 0;
          do_reset();
          for (int k = 0; k < 6; k++) push((base + 2 * k + 1) % 32, k % 3, 16'h100 * k + a);
          kmin = -1;
          for (int k = 5; k >= s; k--) if (k % 3 == a) kmin = k;
          store((base + 2 * s) % 32, a);
          check("R6 rb_valid", rb_valid, (kmin >= 0) ? 1 : 0);
          if (kmin >= 0) check("R6 rb_tag oldest", rb_tag, (base + 2 * kmin + 1) % 32);
          for (int k = 0; k < 6; k++) begin
            look((base + 2 * k + 1) % 32, h, d);
            check("R7 presence", h, (kmin < 0 || k < kmin) ? 1 : 0);
          end
          @(negedge clk);
          check("R6 one-cycle pulse", rb_valid, 0);
        end
      end
    end

    // R8 same-cycle store and load
    do_reset();
    push(5, 7, 16'h55);
    ld_valid = 1; ld_tag = 8; ld_addr = 3; ld_data = 16'h88;
    st_valid = 1; st_tag = 6; st_addr = 3;
    @(negedge clk);
    ld_valid = 0; st_valid = 0;
    check("R8 rb_valid younger load", rb_valid, 1);
    check("R8 rb_tag younger load", rb_tag, 8);
    look(8, h, d);
    check("R8 not inserted", h, 0);
    look(5, h, d);
    check("R8 older entry kept", h, 1);
    ld_valid = 1; ld_tag = 9; ld_addr = 4; ld_data = 16'h99;
    st_valid = 1; st_tag = 10; st_addr = 4;
    @(negedge clk);
    ld_valid = 0; st_valid = 0;
    check("R8 older load no rb", rb_valid, 0);
    look(9, h, d);
    check("R8 older load inserted", h, 1);
    check("R8 older load data", d, 16'h99);
    push(12, 6, 16'hC);
    ld_valid = 1; ld_tag = 13; ld_addr = 6; ld_data = 16'hD;
    st_valid = 1; st_tag = 11; st_addr = 6;
    @(negedge clk);
    ld_valid = 0; st_valid = 0;
    check("R8 buffered older wins", rb_tag, 12);
    check("R8 rb_valid", rb_valid, 1);
    look(13, h, d);
    check("R8 incoming dropped", h, 0);
    look(12, h, d);
    check("R7 offender removed", h, 0);
    look(9, h, d);
    check("R7 older kept", h, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule